// File: doc/BRIEF.md
# NAND Page Layout Stream Mapper

This block walks the physical byte order of one NAND page and, for every byte position, says where that byte belongs in the logical view of the page. The logical view is a contiguous user data buffer plus a spare area. The spare area holds the bad-block marker, a metadata field and one ECC field per packet. A surrounding datapath uses the emitted descriptors to route each flash byte to or from the right buffer location. ECC coding, the flash bus and DMA live elsewhere.

The physical page opens with a 4-byte metadata field. Packets follow, each as its data and then its ECC bytes. A 6-byte bad-block marker sits at a physical offset equal to the page size, so the last packet's data is split around it. Page size, packet size and ECC strength come in as configuration, which must stay stable while a page is being walked. A start pulse launches a walk. Descriptors leave on a valid/ready stream: one byte position advances per cycle in which both are high. While ready is low, the current descriptor is held unchanged and nothing is lost. A one-cycle done pulse ends the walk.

Top module: `nand_layout_mapper`

## Requirements
- R1: After an accepted start, the first 4 descriptors carry region code 1 (metadata), with spare-area indices 6, 7, 8 and 9 in that order.
- R2: ECC byte count per packet is ceil(strength x 15 / 8) and appears on `ecc_bytes`. While the bytes remaining before the marker offset exceed one packet, a whole packet is emitted: packet-size descriptors with region code 0 (data), then ECC-count descriptors with region code 2 (ECC). The remaining count starts at the page size and, after each whole packet, is the page size minus the physical position reached.
- R3: The last packet is emitted in four parts, in this order: its data up to the marker offset, 6 descriptors with region code 3 (marker) and indices 0 to 5, the rest of its data, then its ECC. A data part of zero length is skipped.
- R4: Data descriptors carry buffer indices 0, 1, 2, ... with no gaps across all packets. ECC byte j of packet i carries spare index 10 + i x ECC count + j. `out_pkt` gives the packet number.
- R5: A descriptor is consumed only in a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, region, index and packet number hold steady.
- R6: `busy` is high from the cycle after an accepted start until the final ECC byte is consumed. `done` is high for exactly one cycle, the cycle right after that final byte.
- R7: A start pulse while busy is ignored, and the walk in progress continues unchanged.
- R8: `cfg_err` is high when the packet size is 0, the strength is 0, or the page size is not a multiple of the packet size. A start while `cfg_err` is high is ignored.
- R9: `prot_first` equals packet size + 4, because the first packet also covers the metadata. `prot_rest` equals the packet size.
- R10: After reset, `busy`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_size | input | PAGE_W | Data bytes per page |
| cfg_pkt_size | input | PAGE_W | Data bytes per packet |
| cfg_strength | input | STR_W | ECC correction strength in bits |
| start | input | 1 | Starts a page walk when idle |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Consumer accepts the descriptor |
| out_region | output | 2 | 0 data, 1 metadata, 2 ECC, 3 marker |
| out_index | output | PAGE_W+1 | Buffer index for data, otherwise spare-area offset |
| out_pkt | output | PAGE_W | Current packet number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| cfg_err | output | 1 | Configuration is unusable |
| ecc_bytes | output | STR_W+1 | ECC bytes per packet |
| prot_first | output | PAGE_W+1 | Bytes protected by packet 0 |
| prot_rest | output | PAGE_W | Bytes protected by later packets |

## Verification
Several geometries are walked, and each resulting descriptor sequence is compared byte for byte against an independently computed layout.

- A four-packet page shows that whole packets repeat and that ECC offsets advance by the ECC count.
- A single-packet page puts the whole packet before the marker, so the second data part has zero length and must be skipped.
- Two small pages split the last packet unevenly, which checks the remaining-count arithmetic.

Pseudo-random back-pressure is applied to separate correct stalling from dropped or repeated bytes. Further cases cover a start pulse during a walk, and the three kinds of bad configuration together with the rejection of a start under each.

// File: rtl/nand_map_pkg.sv
package nand_map_pkg;
  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_META = 2'd1,
    RG_ECC  = 2'd2,
    RG_MARK = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_META, PH_DATA, PH_ECC, PH_SPLIT_A, PH_MARK, PH_SPLIT_B, PH_ECC_END
  } phase_e;

  localparam int META_BYTES = 4;
  localparam int MARK_BYTES = 6;
  localparam int GF_ORDER   = 15;
  localparam int SPARE_ECC0 = MARK_BYTES + META_BYTES;
endpackage

// File: rtl/nml_geom.sv
module nml_geom #(
  parameter int PAGE_W = 12,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_size,
  input  logic [PAGE_W-1:0] pkt_size,
  input  logic [STR_W-1:0]  strength,
  output logic [STR_W:0]    ecc_bytes,
  output logic              cfg_err,
  output logic [PAGE_W:0]   prot_first,
  output logic [PAGE_W-1:0] prot_rest
);
  import nand_map_pkg::*;
  localparam int PW = STR_W + 5;

  logic [PW-1:0]     bits_needed;
  logic [PW-1:0]     rounded;
  logic [PAGE_W-1:0] page_mod;

  assign bits_needed = PW'(strength) * PW'(GF_ORDER);
  assign rounded     = (bits_needed + PW'(7)) >> 3;
  assign ecc_bytes   = rounded[STR_W:0];
  assign page_mod    = (pkt_size != '0) ? (page_size % pkt_size) : '0;
  assign cfg_err     = (pkt_size == '0) || (strength == '0) || (page_mod != '0);
  assign prot_first  = {1'b0, pkt_size} + (PAGE_W+1)'(META_BYTES);
  assign prot_rest   = pkt_size;

  // R2: ECC count is the smallest byte count that holds strength*15 bits
  assert_ecc_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strength != '0) |-> ((PW'(ecc_bytes) << 3) >= bits_needed) &&
                         ((PW'(ecc_bytes - 1'b1) << 3) < bits_needed));
endmodule

// File: rtl/nml_seq.sv
module nml_seq #(
  parameter int PAGE_W = 12,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_size,
  input  logic [PAGE_W-1:0] pkt_size,
  input  logic [STR_W:0]    ecc_bytes,
  input  logic              cfg_err,
  input  logic              start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_region,
  output logic [PAGE_W:0]   out_index,
  output logic [PAGE_W-1:0] out_pkt,
  output logic              busy,
  output logic              done
);
  import nand_map_pkg::*;
  localparam int IDX_W = PAGE_W + 1;
  localparam int POS_W = PAGE_W + 2;

  phase_e            phase;
  logic [PAGE_W-1:0] cnt, len, rem, rem_after;
  logic [POS_W-1:0]  pos, pos_nxt;
  logic [IDX_W-1:0]  didx, eidx;
  logic [PAGE_W-1:0] pktn;
  logic              beat, last;
  region_e           region;

  function automatic phase_e pick(input logic [PAGE_W-1:0] r, input logic [PAGE_W-1:0] p);
    if (r > p)        return PH_DATA;
    else if (r != '0) return PH_SPLIT_A;
    else              return PH_MARK;
  endfunction

  always_comb begin
    unique case (phase)
      PH_META:             len = PAGE_W'(META_BYTES);
      PH_DATA:             len = pkt_size;
      PH_ECC, PH_ECC_END:  len = PAGE_W'(ecc_bytes);
      PH_SPLIT_A:          len = rem;
      PH_MARK:             len = PAGE_W'(MARK_BYTES);
      PH_SPLIT_B:          len = pkt_size - rem;
      default:             len = PAGE_W'(1);
    endcase
    unique case (phase)
      PH_META:            region = RG_META;
      PH_ECC, PH_ECC_END: region = RG_ECC;
      PH_MARK:            region = RG_MARK;
      default:            region = RG_DATA;
    endcase
  end

  assign busy      = (phase != PH_IDLE);
  assign out_valid = busy;
  assign beat      = out_valid && out_ready;
  assign last      = beat && (cnt == len - 1'b1);
  assign pos_nxt   = pos + 1'b1;
  assign rem_after = (pos_nxt >= POS_W'(page_size)) ? '0 : PAGE_W'(POS_W'(page_size) - pos_nxt);
  assign out_region = region;
  assign out_pkt    = pktn;

  always_comb begin
    unique case (region)
      RG_META: out_index = IDX_W'(MARK_BYTES) + IDX_W'(cnt);
      RG_MARK: out_index = IDX_W'(cnt);
      RG_ECC:  out_index = eidx;
      default: out_index = didx;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pos   <= '0;
      rem   <= '0;
      didx  <= '0;
      eidx  <= '0;
      pktn  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start && !cfg_err) begin
          phase <= PH_META;
          cnt   <= '0;
          pos   <= '0;
          rem   <= page_size;
          didx  <= '0;
          eidx  <= IDX_W'(SPARE_ECC0);
          pktn  <= '0;
        end
      end else if (beat) begin
        pos <= pos_nxt;
        cnt <= last ? '0 : cnt + 1'b1;
        if (region == RG_DATA) didx <= didx + 1'b1;
        if (region == RG_ECC)  eidx <= eidx + 1'b1;
        if (last) begin
          unique case (phase)
            PH_META:    phase <= pick(rem, pkt_size);
            PH_DATA:    phase <= PH_ECC;
            PH_ECC: begin
              rem   <= rem_after;
              pktn  <= pktn + 1'b1;
              phase <= pick(rem_after, pkt_size);
            end
            PH_SPLIT_A: phase <= PH_MARK;
            PH_MARK:    phase <= (pkt_size != rem) ? PH_SPLIT_B : PH_ECC_END;
            PH_SPLIT_B: phase <= PH_ECC_END;
            default: begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R5: a stalled descriptor is held unchanged
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_region) && $stable(out_index) && $stable(out_pkt)));
  // R6: done is a single-cycle pulse following a consumed ECC byte
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_ecc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_region == 2'd2) && !busy);
  // R1: every walk opens on metadata index 6
  assert_meta_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_region == 2'd1 && out_index == IDX_W'(6)));
  // R3: marker indices stay inside the 6-byte field
  assert_mark_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 2'd3) |-> (out_index < IDX_W'(MARK_BYTES)));
  // R8: a bad configuration never launches a walk
  assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_err) |=> !busy);
endmodule

// File: rtl/nand_layout_mapper.sv
module nand_layout_mapper #(
  parameter int PAGE_W = 12,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_page_size,
  input  logic [PAGE_W-1:0] cfg_pkt_size,
  input  logic [STR_W-1:0]  cfg_strength,
  input  logic              start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_region,
  output logic [PAGE_W:0]   out_index,
  output logic [PAGE_W-1:0] out_pkt,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic [STR_W:0]    ecc_bytes,
  output logic [PAGE_W:0]   prot_first,
  output logic [PAGE_W-1:0] prot_rest
);
  nml_geom #(.PAGE_W(PAGE_W), .STR_W(STR_W)) u_geom (
    .clk(clk), .rst_n(rst_n),
    .page_size(cfg_page_size), .pkt_size(cfg_pkt_size), .strength(cfg_strength),
    .ecc_bytes(ecc_bytes), .cfg_err(cfg_err),
    .prot_first(prot_first), .prot_rest(prot_rest)
  );

  nml_seq #(.PAGE_W(PAGE_W), .STR_W(STR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .page_size(cfg_page_size), .pkt_size(cfg_pkt_size),
    .ecc_bytes(ecc_bytes), .cfg_err(cfg_err), .start(start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_region(out_region), .out_index(out_index), .out_pkt(out_pkt),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/nand_layout_mapper_tb.sv
module nand_layout_mapper_tb;
  localparam int PAGE_W = 12;
  localparam int STR_W  = 6;
  localparam int NV     = 5;
  // page, packet, strength, expected ECC bytes, stall mode, start-while-busy
  localparam int VEC [NV][6] = '{
    '{256,  64, 4,  8, 0, 0},
    '{256,  64, 4,  8, 1, 0},
    '{128, 128, 8, 15, 1, 0},
    '{ 64,  32, 1,  2, 0, 1},
    '{ 96,  32, 2,  4, 1, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PAGE_W-1:0] cfg_page_size = '0, cfg_pkt_size = '0;
  logic [STR_W-1:0]  cfg_strength = '0;
  logic start = 1'b0, out_ready = 1'b0;
  logic out_valid, busy, done, cfg_err;
  logic [1:0] out_region;
  logic [PAGE_W:0] out_index, prot_first;
  logic [PAGE_W-1:0] out_pkt, prot_rest;
  logic [STR_W:0] ecc_bytes;

  int tests = 0, fails = 0, cycles = 0;
  int exp_reg [0:1023];
  int exp_idx [0:1023];
  int exp_n;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  nand_layout_mapper #(.PAGE_W(PAGE_W), .STR_W(STR_W)) u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int r, input int i);
    exp_reg[exp_n] = r;
    exp_idx[exp_n] = i;
    exp_n++;
  endtask

  task automatic build(input int page, input int pkt, input int eb);
    int pos, rem, d, e;
    exp_n = 0; d = 0; e = 10;
    for (int j = 0; j < 4; j++) push(1, 6 + j);
    pos = 4; rem = page;
    while (rem > pkt) begin
      for (int j = 0; j < pkt; j++) push(0, d++);
      for (int j = 0; j < eb; j++) push(2, e++);
      pos += pkt + eb;
      rem = (page > pos) ? page - pos : 0;
    end
    for (int j = 0; j < rem; j++) push(0, d++);
    for (int j = 0; j < 6; j++) push(3, j);
    for (int j = 0; j < pkt - rem; j++) push(0, d++);
    for (int j = 0; j < eb; j++) push(2, e++);
  endtask

  task automatic run(input int v);
    int beat, cyc, bad_meta, bad_ecc, bad_mark, bad_data, early_done, last_pkt;
    beat = 0; cyc = 0; bad_meta = 0; bad_ecc = 0; bad_mark = 0; bad_data = 0;
    early_done = 0; last_pkt = 0;
    @(negedge clk);
    cfg_page_size = PAGE_W'(VEC[v][0]);
    cfg_pkt_size  = PAGE_W'(VEC[v][1]);
    cfg_strength  = STR_W'(VEC[v][2]);
    build(VEC[v][0], VEC[v][1], VEC[v][3]);
    #1;
    check(ecc_bytes == (STR_W+1)'(VEC[v][3]), "R2 ecc count", int'(ecc_bytes), VEC[v][3]);
    check(prot_first == (PAGE_W+1)'(VEC[v][1] + 4) && prot_rest == PAGE_W'(VEC[v][1]),
          "R9 protected size", int'(prot_first), VEC[v][1] + 4);
    check(!cfg_err, "R8 good cfg", int'(cfg_err), 0);
    start = 1'b1;
    while (beat < exp_n && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (VEC[v][5] != 0 && beat == 10) ? 1'b1 : 1'b0;   // R7 stimulus
      out_ready = (VEC[v][4] != 0) ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (done) early_done++;
      if (out_valid && out_ready) begin
        if (out_region != 2'(exp_reg[beat]) || out_index != (PAGE_W+1)'(exp_idx[beat])) begin
          case (exp_reg[beat])
            1: bad_meta++;
            2: bad_ecc++;
            3: bad_mark++;
            default: bad_data++;
          endcase
          if (bad_meta + bad_ecc + bad_mark + bad_data == 1)
            $display("  beat %0d: region %0d index %0d, expected region %0d index %0d",
                     beat, out_region, out_index, exp_reg[beat], exp_idx[beat]);
        end
        last_pkt = int'(out_pkt);
        beat++;
      end
    end
    start = 1'b0;
    out_ready = 1'b1;
    check(bad_meta == 0, "R1 metadata prefix", bad_meta, 0);
    check(bad_ecc == 0, "R2 whole packets and ECC offsets", bad_ecc, 0);
    check(bad_mark == 0, "R3 marker split", bad_mark, 0);
    check(bad_data == 0, "R4 contiguous data index", bad_data, 0);
    check(beat == exp_n, "R5 beats consumed", beat, exp_n);
    check(last_pkt == VEC[v][0] / VEC[v][1] - 1, "R4 packet number", last_pkt, VEC[v][0] / VEC[v][1] - 1);
    @(negedge clk); #1;
    check(done && !busy && early_done == 0, "R6 done after final byte", int'(done), 1);
    @(negedge clk); #1;
    check(!done && !busy, "R6 done single cycle", int'(done), 0);
    if (VEC[v][5] != 0)
      check(!busy, "R7 mid-walk start ignored", int'(busy), 0);
  endtask

  task automatic bad_cfg(input int page, input int pkt, input int str, input string what);
    @(negedge clk);
    cfg_page_size = PAGE_W'(page);
    cfg_pkt_size  = PAGE_W'(pkt);
    cfg_strength  = STR_W'(str);
    #1;
    check(cfg_err, {"R8 cfg_err ", what}, int'(cfg_err), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); #1;
    check(!busy && !out_valid, {"R8 start rejected ", what}, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !out_valid && !done, "R10 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !out_valid && !done, "R10 idle after reset", int'(out_valid), 0);
    for (int v = 0; v < NV; v++) run(v);
    bad_cfg(100, 32, 4, "non-multiple");
    bad_cfg(128, 0, 4, "zero packet");
    bad_cfg(128, 64, 0, "zero strength");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule